// File: doc/BRIEF.md
# PHY Management Command Register

This block is a single 32-bit register, reached over a plain register bus, that stands in for management access to one attached Ethernet PHY. Software writes a command word that carries a PHY/register address field, a read opcode and a data field. Any later read of the same register returns a reply straight away. There is no serial management transaction. The reply is taken from the latched command: either a hard-wired PHY register value with a read-valid flag, or zero.

The register decodes three PHY register addresses:

- The status register reports link up and autonegotiation able.
- The upper half of the PHY identifier.
- The lower half of the PHY identifier.

Every other address answers with the valid flag alone. The register sits at byte offset 0x010 of a 4 KiB window. All other offsets in the window read as zero and ignore writes.

Top module: `phy_mgmt_port`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the latched command word, so a read of offset 0x010 returns 0 until a read command is written.
- R2: A write (busWrEn high at a rising clock edge) to offset 0x010 stores the full 32-bit busWrData. The reply reflects the new word from that edge on.
- R3: When bit 26 (read opcode) of the latched word is 0, a read of offset 0x010 returns 0, whatever the other bits hold.
- R4: When bit 26 of the latched word is 1, a read of offset 0x010 returns bit 27 set (read valid). Bits 31:28 and 26:16 are 0.
- R5: With the opcode set and bits 25:16 equal to 0x021, the reply is 0x0800000C (bit 2 link up, bit 3 autonegotiation able).
- R6: With the opcode set and bits 25:16 equal to 0x041, the reply is 0x08000141.
- R7: With the opcode set and bits 25:16 equal to 0x061, the reply is 0x08000E20.
- R8: With the opcode set and any other value in bits 25:16, the reply is 0x08000000. Bits 15:0 and 27 of the command never change the reply.
- R9: Writes to any byte offset other than 0x010 (full 12-bit compare) leave the latched command unchanged.
- R10: Reads of any byte offset other than 0x010 return 0.
- R11: Reads are combinational on busAddr and the latched word and have no side effects. Repeated or interleaved reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte offset within the 4 KiB register window |
| busWrEn | input | 1 | Write strobe, sampled at the rising clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational on busAddr |

## Verification
A write takes effect at the rising edge where busWrEn is high. The reply for the new command is therefore due in the same cycle, right after that edge, with no further register on the path. Reads carry no latency at all: a change of busAddr shows on busRdData within the same cycle.

The bench drives every input on the falling edge and samples busRdData 1 ns after changing the address. This keeps each sample well clear of the next rising edge. Reset is asynchronous, so its effect is checked 1 ns after rst_n falls, without waiting for a clock.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  // Field positions inside the command word (decoded by the responder)
  localparam int CMD_W        = 32;
  localparam int DATA_LSB     = 0;
  localparam int DATA_MSB     = 15;
  localparam int ADDR_LSB     = 16;
  localparam int ADDR_MSB     = 25;
  localparam int ADDR_W       = ADDR_MSB - ADDR_LSB + 1;
  localparam int OPCODE_BIT   = 26;
  localparam int VALID_BIT    = 27;

  // Strobes from control to datapath
  typedef struct packed {
    logic cmdWrite;   // latch busWrData into the command word
    logic cmdSelect;  // the command register is addressed for read
  } mgmt_strobe_t;

endpackage

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int          BUS_AW     = 12,
  parameter logic [11:0] CMD_OFFSET = 12'h010
) (
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWrEn,
  output mgmt_strobe_t      strobe
);

  localparam logic [BUS_AW-1:0] OFFSET_MATCH = BUS_AW'(CMD_OFFSET);

  logic hit;

  always_comb begin
    hit              = (busAddr == OFFSET_MATCH);
    strobe.cmdSelect = hit;
    strobe.cmdWrite  = hit && busWrEn;
  end

endmodule

// File: rtl/phy_mgmt_resp.sv
module phy_mgmt_resp
  import phy_mgmt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 10'h021,
  parameter logic [ADDR_W-1:0] IDHI_ADDR   = 10'h041,
  parameter logic [ADDR_W-1:0] IDLO_ADDR   = 10'h061,
  parameter logic [15:0]       STATUS_VAL  = 16'h000C,
  parameter logic [31:0]       PHY_ID      = 32'h01410E20
) (
  input  logic              opcodeRead,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [CMD_W-1:0]  reply
);

  localparam int NUM_ENTRIES = 3;
  localparam logic [ADDR_W-1:0] ENTRY_ADDR [NUM_ENTRIES] =
    '{STATUS_ADDR, IDHI_ADDR, IDLO_ADDR};
  localparam logic [15:0] ENTRY_VAL [NUM_ENTRIES] =
    '{STATUS_VAL, PHY_ID[31:16], PHY_ID[15:0]};

  logic [NUM_ENTRIES-1:0] match;
  logic [15:0]            entryData [NUM_ENTRIES];
  logic [15:0]            dataField;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    assign match[i]     = (regAddr == ENTRY_ADDR[i]);
    assign entryData[i] = match[i] ? ENTRY_VAL[i] : 16'h0000;
  end

  always_comb begin
    dataField = 16'h0000;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      dataField = dataField | entryData[i];
    end
  end

  always_comb begin
    reply = '0;
    if (opcodeRead) begin
      reply[VALID_BIT]         = 1'b1;
      reply[DATA_MSB:DATA_LSB] = dataField;
    end
  end

endmodule

// File: rtl/phy_mgmt_dp.sv
module phy_mgmt_dp
  import phy_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  mgmt_strobe_t     strobe,
  input  logic [CMD_W-1:0] busWrData,
  output logic [CMD_W-1:0] cmdWord,
  output logic [CMD_W-1:0] busRdData
);

  logic [CMD_W-1:0] reply;
  logic             unusedCmdBits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdWord <= '0;
    end else if (strobe.cmdWrite) begin
      cmdWord <= busWrData;
    end
  end

  phy_mgmt_resp u_resp (
    .opcodeRead (cmdWord[OPCODE_BIT]),
    .regAddr    (cmdWord[ADDR_MSB:ADDR_LSB]),
    .reply      (reply)
  );

  assign unusedCmdBits = ^{cmdWord[CMD_W-1:VALID_BIT], cmdWord[DATA_MSB:DATA_LSB]};

  assign busRdData = strobe.cmdSelect ? reply : '0;

endmodule

// File: rtl/phy_mgmt_port.sv
module phy_mgmt_port
  import phy_mgmt_pkg::*;
#(
  parameter int          BUS_AW     = 12,
  parameter logic [11:0] CMD_OFFSET = 12'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData
);

  mgmt_strobe_t     strobe;
  logic [CMD_W-1:0] cmdWord;

  phy_mgmt_ctrl #(
    .BUS_AW     (BUS_AW),
    .CMD_OFFSET (CMD_OFFSET)
  ) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  phy_mgmt_dp u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .busWrData (busWrData),
    .cmdWord   (cmdWord),
    .busRdData (busRdData)
  );

endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk #(
  parameter int          BUS_AW     = 12,
  parameter logic [11:0] CMD_OFFSET = 12'h010
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BUS_AW-1:0] busAddr,
  input logic              busWrEn,
  input logic [31:0]       busWrData,
  input logic [31:0]       busRdData,
  input logic [31:0]       cmdWord
);

  localparam logic [BUS_AW-1:0] OFF = BUS_AW'(CMD_OFFSET);

  AST_CMD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busAddr == OFF) |=> (cmdWord == $past(busWrData)));  // R2

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(busWrEn && busAddr == OFF) |=> $stable(cmdWord));  // R9

  AST_NOOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == OFF && !cmdWord[26]) |-> (busRdData == 32'h0));  // R3

  AST_VALID_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == OFF && cmdWord[26]) |-> (busRdData[27] && busRdData[31:28] == 4'h0
                                         && busRdData[26:16] == 11'h0));  // R4

  AST_OFF_WINDOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr != OFF) |-> (busRdData == 32'h0));  // R10

  AST_STATUS_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == OFF && cmdWord[26] && cmdWord[25:16] == 10'h021)
      |-> (busRdData == 32'h0800000C));  // R5

endmodule

bind phy_mgmt_port phy_mgmt_chk #(
  .BUS_AW     (BUS_AW),
  .CMD_OFFSET (CMD_OFFSET)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .cmdWord   (cmdWord)
);

// File: tb/tb_phy_mgmt_port.sv
`timescale 1ns/1ps
module tb_phy_mgmt_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] busAddr = 12'h000;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = 32'h0;
  logic [31:0] busRdData;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  always #5 clk = ~clk;

  phy_mgmt_port dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData)
  );

  // {write offset, write data, read offset, expected read}
  localparam int NV = 13;
  localparam logic [87:0] VEC [NV] = '{
    {12'h010, 32'h04210000, 12'h010, 32'h0800000C},  // R5 status
    {12'h010, 32'h0441FFFF, 12'h010, 32'h08000141},  // R6 id high, data ignored
    {12'h010, 32'h04610000, 12'h010, 32'h08000E20},  // R7 id low
    {12'h010, 32'h04220000, 12'h010, 32'h08000000},  // R8 unknown address
    {12'h010, 32'h00210000, 12'h010, 32'h00000000},  // R3 opcode clear
    {12'h010, 32'h04410000, 12'h010, 32'h08000141},  // R2 new word captured
    {12'h014, 32'h00000000, 12'h010, 32'h08000141},  // R9 neighbour write ignored
    {12'h000, 32'hFFFFFFFF, 12'h000, 32'h00000000},  // R10 other offset reads 0
    {12'h410, 32'h04210000, 12'h010, 32'h08000141},  // R9 aliasing offset ignored
    {12'h010, 32'hF3FF0000, 12'h010, 32'h00000000},  // R3 high bits, no opcode
    {12'h010, 32'hFFFFFFFF, 12'h010, 32'h08000000},  // R8 all ones
    {12'h010, 32'h0C21ABCD, 12'h010, 32'h0800000C},  // R4 valid bit in command
    {12'h018, 32'h04610000, 12'h01C, 32'h00000000}   // R10 another offset
  };

  function automatic string vecTag(int i);
    case (i)
      0: return "R5";  1: return "R6";  2: return "R7";  3: return "R8";
      4: return "R3";  5: return "R2";  6: return "R9";  7: return "R10";
      8: return "R9";  9: return "R3";  10: return "R8"; 11: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] exp);
    testCount++;
    if (busRdData !== exp) begin
      failCount++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, busRdData, exp);
    end
  endtask

  task automatic busWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr   = a;
    busWrData = d;
    busWrEn   = 1'b1;
    @(negedge clk);
    busWrEn   = 1'b0;
  endtask

  task automatic busRead(logic [11:0] a, string tag, logic [31:0] exp);
    busAddr = a;
    #1;
    check(tag, exp);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    // R1: reset state
    busAddr = 12'h010;
    #1;
    check("R1", 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    busRead(12'h010, "R1", 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      busWrite(VEC[i][87:76], VEC[i][75:44]);
      busRead(VEC[i][43:32], vecTag(i), VEC[i][31:0]);
    end

    // R2: reply valid right after the capturing edge, same cycle
    @(negedge clk);
    busAddr   = 12'h010;
    busWrData = 32'h04610000;
    busWrEn   = 1'b1;
    @(posedge clk);
    #1;
    busWrEn = 1'b0;
    check("R2", 32'h08000E20);

    // R11: interleaved and repeated reads without side effects
    @(negedge clk);
    busRead(12'h000, "R11", 32'h0);
    busRead(12'h010, "R11", 32'h08000E20);
    repeat (3) @(negedge clk);
    busRead(12'h010, "R11", 32'h08000E20);

    // R1: asynchronous reset mid-run clears the command
    busWrite(12'h010, 32'h04210000);
    busRead(12'h010, "R5", 32'h0800000C);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    busRead(12'h010, "R1", 32'h0);

    finish();
  end

endmodule